// File: doc/BRIEF.md
# DMA Bus Error Cause Register

This block is a byte-wide status register. It records why the most recent local-bus error happened while a network controller's DMA engine was moving data. When a DMA transfer ends in an error, the DMA side pulses a transfer-error strobe and presents a 2-bit source code in the same cycle. The register then loads three cause flags: local timeout, external backplane bus error and DRAM parity error. Every capture rewrites all three flags together, so at most one flag is ever set. An error whose source is not one of the three known kinds leaves all three flags cleared.

A CPU-side register port gives software byte access at one fixed address. A read returns the three flags in the top bits of the byte. Writing 1 to the lowest bit of the byte clears all three flags. That clear bit always reads back as 0. There is no data stream here, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `dbe_status_reg`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, all three flags are 0 and the register byte reads 0x00.
- R2: An error strobe with source code 2'b01 (local timeout) makes the byte read 0x20 from the next rising edge onward (bit 5 set, bits 7 and 6 cleared).
- R3: An error strobe with source code 2'b10 (external bus) makes the byte read 0x40 from the next rising edge onward (bit 6 set, bits 7 and 5 cleared).
- R4: An error strobe with source code 2'b11 (parity) makes the byte read 0x80 from the next rising edge onward (bit 7 set, bits 6 and 5 cleared).
- R5: An error strobe with source code 2'b00 (other cause) clears all three flags at the next rising edge.
- R6: A write to the register address with data bit 0 set clears all three flags at the next rising edge.
- R7: Writing 0 to bit 0 has no effect on the flags, and writing bits 4 to 1 has no effect either. Bits 4 to 0 always read as 0.
- R8: A write to any address other than the register address leaves the flags unchanged.
- R9: If a clearing write and an error strobe fall in the same cycle, the error capture takes effect and the clear is dropped.
- R10: At most one of the three flags is set at any time.
- R11: Read data is combinational. cpu_rdata shows the register byte while cpu_addr matches the register address and reads 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 1 | One-cycle DMA transfer-error pulse |
| err_src | input | 2 | Error source code: 00 other, 01 timeout, 10 external bus, 11 parity |
| cpu_addr | input | ADDR_W (8) | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data byte |
| cpu_rdata | output | 8 | CPU read data byte |

## Verification
Two functions can fall in the same cycle: an error capture and a software clear. The bench provokes this by pulsing err_strobe with each source code in the same cycle as a matching-address write with bit 0 set. The surviving flag pattern must be the one that error's source code selects. A bench-side reference model applies the rule that capture wins on every edge, so each collision produced by the directed and pseudo-random stimulus is judged against the register byte in the following cycle.

// File: rtl/dbe_pkg.sv
package dbe_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIT_PAR = 7;
  localparam int unsigned BIT_EXT = 6;
  localparam int unsigned BIT_TMO = 5;
  localparam int unsigned BIT_CLR = 0;

  typedef enum logic [1:0] {
    SRC_OTHER   = 2'b00,
    SRC_TIMEOUT = 2'b01,
    SRC_EXTBUS  = 2'b10,
    SRC_PARITY  = 2'b11
  } err_src_e;

  typedef struct packed {
    logic parity;
    logic extbus;
    logic timeout;
  } cause_flags_t;

  localparam cause_flags_t FLAGS_NONE = '{parity: 1'b0, extbus: 1'b0, timeout: 1'b0};

endpackage

// File: rtl/dbe_cause_decode.sv
module dbe_cause_decode
  import dbe_pkg::*;
(
  input  logic         err_strobe,
  input  logic [1:0]   err_src,
  output logic         load,
  output cause_flags_t load_val
);

  err_src_e src;
  assign src  = err_src_e'(err_src);
  assign load = err_strobe;

  always_comb begin
    load_val = FLAGS_NONE;
    unique case (src)
      SRC_TIMEOUT: load_val.timeout = 1'b1;
      SRC_EXTBUS:  load_val.extbus  = 1'b1;
      SRC_PARITY:  load_val.parity  = 1'b1;
      default:     load_val         = FLAGS_NONE;
    endcase
  end

endmodule

// File: rtl/dbe_host_port.sv
module dbe_host_port
  import dbe_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h28
) (
  input  logic                 cpu_wr,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [BYTE_W-1:0]    cpu_wdata,
  input  cause_flags_t         flags,
  output logic                 clr_req,
  output logic [BYTE_W-1:0]    cpu_rdata
);

  logic hit;
  assign hit     = (cpu_addr == REG_ADDR);
  assign clr_req = hit && cpu_wr && cpu_wdata[BIT_CLR];

  always_comb begin
    cpu_rdata = '0;
    if (hit) begin
      cpu_rdata[BIT_PAR] = flags.parity;
      cpu_rdata[BIT_EXT] = flags.extbus;
      cpu_rdata[BIT_TMO] = flags.timeout;
    end
  end

  always_comb begin
    AST_LOW_BITS_ZERO: assert (cpu_rdata[4:0] == 5'b0); // R7
  end

endmodule

// File: rtl/dbe_flag_store.sv
module dbe_flag_store
  import dbe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  cause_flags_t load_val,
  input  logic         clr_req,
  output cause_flags_t flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= FLAGS_NONE;
    else if (load)    flags <= load_val;
    else if (clr_req) flags <= FLAGS_NONE;
  end

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags)); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !load) |=> (flags == FLAGS_NONE)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !load) |=> $stable(flags)); // R7

endmodule

// File: rtl/dbe_status_reg.sv
module dbe_status_reg
  import dbe_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_strobe,
  input  logic [1:0]        err_src,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata
);

  logic         load;
  cause_flags_t load_val;
  logic         clr_req;
  cause_flags_t flags;

  dbe_cause_decode u_dec (
    .err_strobe (err_strobe),
    .err_src    (err_src),
    .load       (load),
    .load_val   (load_val)
  );

  dbe_host_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .flags     (flags),
    .clr_req   (clr_req),
    .cpu_rdata (cpu_rdata)
  );

  dbe_flag_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .clr_req  (clr_req),
    .flags    (flags)
  );

  AST_TIMEOUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && err_src == 2'b01) |=> (flags == 3'b001)); // R2
  AST_EXTBUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && err_src == 2'b10) |=> (flags == 3'b010)); // R3
  AST_PARITY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && err_src == 2'b11) |=> (flags == 3'b100)); // R4
  AST_OTHER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && err_src == 2'b00) |=> (flags == 3'b000)); // R5
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_strobe && cpu_addr != REG_ADDR) |=> $stable(flags)); // R8
  AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && err_src != 2'b00 && clr_req) |=> (flags != 3'b000)); // R9

endmodule

// File: tb/sim_dbe_status_reg.sv
`timescale 1ns/1ps
module sim_dbe_status_reg;

  localparam logic [7:0] RA = 8'h28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_strobe = 1'b0;
  logic [1:0] err_src = 2'b00;
  logic [7:0] cpu_addr = RA;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit m_par = 0, m_ext = 0, m_tmo = 0;

  always #2.5 clk = ~clk;

  dbe_status_reg #(.ADDR_W(8), .REG_ADDR(RA)) u0 (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_src(err_src),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata)
  );

  // Behavioural reference: capture has priority over a clearing write.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_par = 0; m_ext = 0; m_tmo = 0;
    end else if (err_strobe) begin
      m_tmo = (err_src == 2'b01);
      m_ext = (err_src == 2'b10);
      m_par = (err_src == 2'b11);
    end else if (cpu_wr && cpu_addr == RA && cpu_wdata[0]) begin
      m_par = 0; m_ext = 0; m_tmo = 0;
    end
  end

  function automatic logic [7:0] expect_byte();
    return (cpu_addr == RA) ? {m_par, m_ext, m_tmo, 5'b00000} : 8'h00;
  endfunction

  task automatic check(input string tag);
    logic [7:0] e;
    e = expect_byte();
    checks++;
    if (cpu_rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected=%02h at %0t", tag, cpu_rdata, e, $time);
    end
  endtask

  // One cycle: check current state, then apply new inputs for the next edge.
  task automatic step(input string tag, input logic es, input logic [1:0] src,
                      input logic [7:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    check(tag);
    err_strobe = es; err_src = src; cpu_addr = a; cpu_wr = w; cpu_wdata = d;
    #1 check("R11");
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 2'b00, RA, 1'b0, 8'h00);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) begin @(negedge clk); check("R1"); end
    rst_n = 1'b1;
    idle("R1");
    step("R1", 1'b1, 2'b01, RA, 1'b0, 8'h00);
    idle("R2");
    step("R2", 1'b1, 2'b10, RA, 1'b0, 8'h00);
    idle("R3");
    step("R3", 1'b1, 2'b11, RA, 1'b0, 8'h00);
    idle("R4");
    step("R4", 1'b1, 2'b00, RA, 1'b0, 8'h00);
    idle("R5");
    step("R5", 1'b1, 2'b11, RA, 1'b0, 8'h00);
    step("R4", 1'b0, 2'b00, RA, 1'b1, 8'h01);
    idle("R6");
    step("R6", 1'b1, 2'b10, RA, 1'b0, 8'h00);
    step("R3", 1'b0, 2'b00, RA, 1'b1, 8'hFE);
    idle("R7");
    step("R7", 1'b0, 2'b00, RA, 1'b1, 8'h1E);
    idle("R7");
    step("R7", 1'b0, 2'b00, 8'h29, 1'b1, 8'hFF);
    step("R11", 1'b0, 2'b00, 8'h29, 1'b0, 8'h00);
    idle("R8");
    step("R8", 1'b1, 2'b01, RA, 1'b1, 8'h01);
    idle("R9");
    step("R9", 1'b1, 2'b11, RA, 1'b1, 8'hFF);
    idle("R9");
    step("R9", 1'b1, 2'b10, RA, 1'b1, 8'h01);
    idle("R9");
    step("R9", 1'b0, 2'b00, RA, 1'b1, 8'hFF);
    idle("R6");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R10", lfsr[0] & lfsr[5], lfsr[2:1], lfsr[3] ? RA : {lfsr[11:8], 4'h3},
           lfsr[4], {lfsr[12:6], lfsr[7]});
    end
    idle("R10");
    idle("R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule